// File: doc/BRIEF.md
# Block Compare Search Sequencer

This block runs a byte search through memory on behalf of a processor core. On a start pulse it captures an 8-bit key (the accumulator), a 16-bit address pointer, a 16-bit byte count, a direction, a repeat mode and an incoming carry. It then issues reads through a simple memory port.

For every byte returned, one step does three things in order. It compares the key with the byte, then moves the pointer one place up or down, then takes one off the count. In single mode the block stops after one step. In repeat mode it keeps stepping until a byte equals the key or the count reaches zero, whichever comes first.

When the sequence ends, the block pulses done. It presents the final pointer, the final count and a flag byte, and holds them until the next start.

Top module: `blk_search_seq`

## Requirements
- R1: After reset, done and mem_rd are low, and ptr_out, cnt_out and flags_out are all zero.
- R2: Each step reads the byte at the current pointer. mem_addr equals the pointer, only one read is outstanding, and mem_rd stays high with a steady mem_addr until mem_rdy is seen high.
- R3: After each step the pointer moves by one: up when dir_down is 0, down when dir_down is 1. It wraps modulo 65536 (FFFFh+1 gives 0000h, 0000h-1 gives FFFFh).
- R4: After each step the count goes down by one. A starting count of zero wraps to FFFFh.
- R5: With rpt_mode low, exactly one read and one step are made per start.
- R6: With rpt_mode high, stepping stops after the first step whose byte equals the key, or whose decremented count is zero. The number of reads equals the number of steps.
- R7: flags_out packs the flags as follows: bit 7 sign, bit 6 zero, bit 4 half-borrow, bit 2 parity/overflow, bit 1 subtract, bit 0 carry; bits 5 and 3 read 0. Zero is set when the key equalled the last byte read. Sign is bit 7 of (key minus byte). Half-borrow is set when the key's low nibble is below the byte's low nibble.
- R8: The parity/overflow bit is 1 when the count after the last decrement is non-zero, and 0 when it is zero.
- R9: The carry bit equals carry_in as captured at start, and the subtract bit is always 1.
- R10: done is high for exactly one cycle, the cycle after the edge that accepts the last mem_rdy. ptr_out, cnt_out and flags_out then stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sequence (taken when idle) |
| acc_in | input | 8 | Search key |
| ptr_in | input | 16 | Initial address pointer |
| cnt_in | input | 16 | Initial byte count |
| dir_down | input | 1 | 1 moves the pointer downward |
| rpt_mode | input | 1 | 1 repeats until match or count zero |
| carry_in | input | 1 | Incoming carry flag |
| mem_addr | output | 16 | Read address |
| mem_rd | output | 1 | Read strobe, held until ready |
| mem_data | input | 8 | Read data, valid with mem_rdy |
| mem_rdy | input | 1 | Read completion |
| done | output | 1 | One-cycle end-of-sequence pulse |
| ptr_out | output | 16 | Final pointer |
| cnt_out | output | 16 | Final count |
| flags_out | output | 8 | Final flag byte |

## Verification
The read strobe rises in the cycle after the start edge. Each read completes on the edge where mem_rdy is high, and the pointer, count and flags registers take their new values on that same edge. done and the final results are therefore due one cycle after the edge that accepts the last ready. A bench memory answers after a latency that changes from test to test. A monitor samples on the falling edge, so it always sees settled values. It counts the read handshakes and compares each done event against the expected item queued by the driver. After each sequence the driver waits several idle cycles and checks that the results have not moved.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  localparam int FLAG_W = 8;
  localparam int S_BIT  = 7;
  localparam int Z_BIT  = 6;
  localparam int H_BIT  = 4;
  localparam int PV_BIT = 2;
  localparam int N_BIT  = 1;
  localparam int C_BIT  = 0;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_READ = 1'b1
  } seq_state_t;
endpackage

// File: rtl/sseq_walker.sv
module sseq_walker #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          dir_down,
  input  logic [AW-1:0] ptr_init,
  input  logic [CW-1:0] cnt_init,
  output logic [AW-1:0] ptr,
  output logic [CW-1:0] cnt,
  output logic          cnt_dec_nz
);
  localparam logic [AW-1:0] PTR_ONE = AW'(1);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] ptr_nxt;
  logic [CW-1:0] cnt_dec;

  // pointer move and count decrement
  always_comb begin
    ptr_nxt    = dir_down ? (ptr - PTR_ONE) : (ptr + PTR_ONE);
    cnt_dec    = cnt - CNT_ONE;
    cnt_dec_nz = |cnt_dec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      cnt <= '0;
    end else if (load) begin
      ptr <= ptr_init;
      cnt <= cnt_init;
    end else if (step) begin
      ptr <= ptr_nxt;
      cnt <= cnt_dec;
    end
  end
endmodule

// File: rtl/sseq_cmp.sv
module sseq_cmp
  import sseq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]     key,
  input  logic [DW-1:0]     rdata,
  input  logic              carry,
  input  logic              cnt_nz,
  output logic              match,
  output logic [FLAG_W-1:0] flags
);
  logic [DW-1:0] diff;
  logic          half_borrow;

  always_comb begin
    diff        = key - rdata;
    match       = (key == rdata);
    half_borrow = (key[3:0] < rdata[3:0]);
    flags          = '0;
    flags[S_BIT]   = diff[DW-1];
    flags[Z_BIT]   = match;
    flags[H_BIT]   = half_borrow;
    flags[PV_BIT]  = cnt_nz;
    flags[N_BIT]   = 1'b1;
    flags[C_BIT]   = carry;
  end
endmodule

// File: rtl/sseq_ctrl.sv
module sseq_ctrl
  import sseq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic mem_rdy,
  input  logic rpt,
  input  logic match,
  input  logic cnt_dec_nz,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  seq_state_t state;
  logic       last;

  always_comb begin
    busy = (state == ST_READ);
    load = start && (state == ST_IDLE);
    step = busy && mem_rdy;
    last = step && (!rpt || match || !cnt_dec_nz);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= last;
      case (state)
        ST_IDLE: if (load) state <= ST_READ;
        ST_READ: if (last) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blk_search_seq.sv
module blk_search_seq
  import sseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DW-1:0]     acc_in,
  input  logic [AW-1:0]     ptr_in,
  input  logic [CW-1:0]     cnt_in,
  input  logic              dir_down,
  input  logic              rpt_mode,
  input  logic              carry_in,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  input  logic [DW-1:0]     mem_data,
  input  logic              mem_rdy,
  output logic              done,
  output logic [AW-1:0]     ptr_out,
  output logic [CW-1:0]     cnt_out,
  output logic [FLAG_W-1:0] flags_out
);
  logic          load, step, busy, match, cnt_dec_nz;
  logic [DW-1:0] key_q;
  logic          dir_q, rpt_q, cy_q;
  logic [AW-1:0] ptr;
  logic [CW-1:0] cnt;
  logic [FLAG_W-1:0] flags_nxt, flags_q;

  // operands captured once per sequence
  always_ff @(posedge clk) begin
    if (rst) begin
      key_q <= '0;
      dir_q <= 1'b0;
      rpt_q <= 1'b0;
      cy_q  <= 1'b0;
    end else if (load) begin
      key_q <= acc_in;
      dir_q <= dir_down;
      rpt_q <= rpt_mode;
      cy_q  <= carry_in;
    end
  end

  sseq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mem_rdy(mem_rdy),
    .rpt(rpt_q), .match(match), .cnt_dec_nz(cnt_dec_nz),
    .load(load), .step(step), .busy(busy), .done(done)
  );

  sseq_walker #(.AW(AW), .CW(CW)) u_walk (
    .clk(clk), .rst(rst), .load(load), .step(step), .dir_down(dir_q),
    .ptr_init(ptr_in), .cnt_init(cnt_in),
    .ptr(ptr), .cnt(cnt), .cnt_dec_nz(cnt_dec_nz)
  );

  sseq_cmp #(.DW(DW)) u_cmp (
    .key(key_q), .rdata(mem_data), .carry(cy_q), .cnt_nz(cnt_dec_nz),
    .match(match), .flags(flags_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)       flags_q <= '0;
    else if (step) flags_q <= flags_nxt;
  end

  assign mem_rd    = busy;
  assign mem_addr  = ptr;
  assign ptr_out   = ptr;
  assign cnt_out   = cnt;
  assign flags_out = flags_q;
endmodule

// File: rtl/sseq_chk.sv
module sseq_chk
  import sseq_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              dir_down,
  input logic              rpt_mode,
  input logic              carry_in,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_rd,
  input logic              mem_rdy,
  input logic              done,
  input logic [AW-1:0]     ptr_out,
  input logic [CW-1:0]     cnt_out,
  input logic [FLAG_W-1:0] flags_out
);
  logic cap_dir, cap_rpt, cap_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_dir <= 1'b0;
      cap_rpt <= 1'b0;
      cap_c   <= 1'b0;
    end else if (start && !mem_rd) begin
      cap_dir <= dir_down;
      cap_rpt <= rpt_mode;
      cap_c   <= carry_in;
    end
  end

  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd && !mem_rdy |=> mem_rd && $stable(mem_addr));
  // R3
  fwd_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd && mem_rdy && !cap_dir |=> !mem_rd || (mem_addr == AW'($past(mem_addr) + 1'b1)));
  // R3
  bwd_step_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd && mem_rdy && cap_dir |=> !mem_rd || (mem_addr == AW'($past(mem_addr) - 1'b1)));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_rd && !start |=> $stable(ptr_out) && $stable(cnt_out) && $stable(flags_out));
  // R9
  carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> flags_out[N_BIT] && (flags_out[C_BIT] == cap_c));
  // R8
  pv_count_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> flags_out[PV_BIT] == (cnt_out != '0));
  // R6
  rpt_stop_chk: assert property (@(posedge clk) disable iff (rst)
    done && cap_rpt && !flags_out[Z_BIT] |-> cnt_out == '0);
  // R7
  spare_bits_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !flags_out[5] && !flags_out[3]);
endmodule

bind blk_search_seq sseq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .dir_down(dir_down),
  .rpt_mode(rpt_mode), .carry_in(carry_in), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_rdy(mem_rdy), .done(done), .ptr_out(ptr_out),
  .cnt_out(cnt_out), .flags_out(flags_out)
);

// File: tb/blk_search_seq_tb.sv
module blk_search_seq_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] ptr;
    logic [15:0] cnt;
    logic [7:0]  flg;
    int          reads;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  acc_in = '0;
  logic [15:0] ptr_in = '0, cnt_in = '0;
  logic        dir_down = 1'b0, rpt_mode = 1'b0, carry_in = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_data = '0;
  logic        mem_rdy = 1'b0;
  logic        done;
  logic [15:0] ptr_out, cnt_out;
  logic [7:0]  flags_out;

  int n_chk = 0, n_fail = 0, lat = 0, wc = 0, rd_cnt = 0;
  logic prev_done = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_search_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .acc_in(acc_in), .ptr_in(ptr_in),
    .cnt_in(cnt_in), .dir_down(dir_down), .rpt_mode(rpt_mode), .carry_in(carry_in),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_data(mem_data), .mem_rdy(mem_rdy),
    .done(done), .ptr_out(ptr_out), .cnt_out(cnt_out), .flags_out(flags_out)
  );

  function automatic logic [7:0] mdat(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: answers after lat idle cycles, one read at a time
  always @(posedge clk) begin
    if (rst) begin
      mem_rdy <= 1'b0;
      wc      <= 0;
    end else if (mem_rdy) begin
      mem_rdy <= 1'b0;
    end else if (mem_rd) begin
      if (wc >= lat) begin
        mem_rdy  <= 1'b1;
        mem_data <= mdat(mem_addr);
        wc       <= 0;
      end else begin
        wc <= wc + 1;
      end
    end
  end

  // monitor: pops expected items on done
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd && mem_rdy) rd_cnt++;
      if (prev_done) check("R10 done width", {31'd0, done}, 32'd0);
      if (done) begin
        if (sb.size() == 0) begin
          check("R10 unexpected done", 32'd1, 32'd0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check({"R3 ptr ", e.tag}, {16'd0, ptr_out}, {16'd0, e.ptr});
          check({"R4 cnt ", e.tag}, {16'd0, cnt_out}, {16'd0, e.cnt});
          check({"R7 R8 R9 flags ", e.tag}, {24'd0, flags_out}, {24'd0, e.flg});
          check({"R5 R6 reads ", e.tag}, rd_cnt, e.reads);
        end
        rd_cnt = 0;
      end
      prev_done = done;
    end
  end

  task automatic run_op(input string tag, input logic [7:0] a, input logic [15:0] p0,
                        input logic [15:0] c0, input logic dn, input logic rp,
                        input logic cy, input int latency);
    exp_t e;
    logic [15:0] p = p0, c = c0;
    logic [7:0] d = '0, df = '0;
    logic m = 1'b0;
    logic h = 1'b0;
    int n = 0;
    logic [15:0] hp;
    logic [15:0] hc;
    logic [7:0] hf;
    forever begin
      d  = mdat(p);
      m  = (a == d);
      df = a - d;
      h  = (a[3:0] < d[3:0]);
      p  = dn ? p - 16'd1 : p + 16'd1;
      c  = c - 16'd1;
      n++;
      if (!rp || m || c == 16'd0) break;
    end
    e.ptr = p; e.cnt = c; e.reads = n; e.tag = tag;
    e.flg = {df[7], m, 1'b0, h, 1'b0, (c != 16'd0), 1'b1, cy};
    sb.push_back(e);
    lat = latency;
    @(negedge clk);
    acc_in = a; ptr_in = p0; cnt_in = c0; dir_down = dn; rpt_mode = rp; carry_in = cy;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    hp = ptr_out; hc = cnt_out; hf = flags_out;
    repeat (3) @(negedge clk);
    check({"R10 hold ", tag}, {hp, hc}, {ptr_out, cnt_out});
    check({"R10 hold flags ", tag}, {24'd0, hf}, {24'd0, flags_out});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 done/rd", {30'd0, done, mem_rd}, 32'd0);
    check("R1 ptr/cnt", {ptr_out, cnt_out}, 32'd0);
    check("R1 flags", {24'd0, flags_out}, 32'd0);

    run_op("R5 single fwd nomatch", 8'h00, 16'h1234, 16'd5, 1'b0, 1'b0, 1'b0, 0);
    run_op("R7 single bwd match",   8'h26, 16'h1234, 16'd5, 1'b1, 1'b0, 1'b1, 2);
    run_op("R8 single count one",   8'h5A, 16'h0F0F, 16'd1, 1'b0, 1'b0, 1'b1, 1);
    run_op("R4 count zero wrap",    8'h11, 16'h2222, 16'd0, 1'b0, 1'b0, 1'b0, 0);
    run_op("R3 fwd ptr wrap",       8'h00, 16'hFFFF, 16'd3, 1'b0, 1'b0, 1'b0, 1);
    run_op("R3 bwd ptr wrap",       8'hFF, 16'h0000, 16'd3, 1'b1, 1'b0, 1'b1, 0);
    run_op("R6 rpt fwd match",      8'h17, 16'h1000, 16'd40, 1'b0, 1'b1, 1'b0, 1);
    run_op("R6 rpt exhaust",        8'hFF, 16'h1000, 16'd20, 1'b0, 1'b1, 1'b1, 0);
    run_op("R6 rpt bwd match",      8'h68, 16'h2050, 16'd100, 1'b1, 1'b1, 1'b0, 3);
    run_op("R4 rpt from zero",      8'h35, 16'h3000, 16'd0, 1'b0, 1'b1, 1'b1, 2);
    run_op("R7 rpt first hit",      8'h00, 16'h4040, 16'd9, 1'b1, 1'b1, 1'b0, 0);
    run_op("R2 slow memory",        8'h42, 16'h4000, 16'd8, 1'b0, 1'b1, 1'b0, 5);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule